// File: doc/BRIEF.md
# Single-Channel Request-Driven DMA Controller

This block is one DMA channel. Each time the selected hardware request fires, it copies one unit of data, a byte or a 16-bit word, between two addresses. One address is a memory pointer that steps after every copy. The other is a fixed peripheral address. Software loads the two addresses, a transfer count and a control byte through a small register port, then sets the enable bit. After that the channel serves requests until the count runs out. At that point it disables itself and, if allowed, raises a level interrupt.

The copy direction has no register bit of its own. It follows from the selected request source. The serial receive-full source and the converter-done source read from the peripheral address and write to memory. Every other source reads memory and writes to the peripheral address. Each copy takes two single-beat bus accesses on the master port: one read, then one write. A request that arrives during a copy is held, one deep, and served when the copy ends. Only the non-repeating mode is provided.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset the memory pointer, peripheral address, count and control registers read 0, `irq` is 0 and `bus_req` is 0.
- R2: Each accepted request produces exactly one read beat followed by exactly one write beat. Both beats carry `bus_word` equal to control bit 3 (1 = 16-bit word, 0 = byte on bits 7:0).
- R3: When the source select is 4 or 5, the read beat uses the peripheral address and the write beat uses the memory pointer. For every other source the read beat uses the memory pointer and the write beat uses the peripheral address.
- R4: Control bits 2:0 select the request line: 0, 1 and 2 are timer channels 0 to 2, 3 is serial transmit-empty, 4 is serial receive-full, 5 is converter-done, 6 is the external request and 7 selects no line. Pulses on lines that are not selected cause no bus activity.
- R5: After each copy the memory pointer moves by 1 (byte) or 2 (word). It moves down when control bit 4 is 1 and up when it is 0. The peripheral address never changes.
- R6: Each copy lowers the count by one. The copy that brings the count to zero also clears the enable bit (control bit 7), and later requests cause no bus activity.
- R7: Requests are accepted only while control bit 7 (enable) is 1, control bit 5 (repeat) is 0 and the count is nonzero.
- R8: `irq` is 1 when the count has run out and control bit 6 is 1. Any write to the control register clears it.
- R9: A selected request that arrives while a copy is in progress is held and served after that copy. At most one request is held.
- R10: The register addresses are 0 for the memory pointer, 1 for the peripheral address, 2 for the count and 3 for control. Read data appears on `reg_rdata` one clock after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Registered read data |
| req_tmr | input | 3 | Timer channel 0 to 2 request pulses |
| req_txe | input | 1 | Serial transmit-empty request pulse |
| req_rxf | input | 1 | Serial receive-full request pulse |
| req_adc | input | 1 | Converter-done request pulse |
| req_ext | input | 1 | External request pulse |
| bus_req | output | 1 | Bus beat active |
| bus_we | output | 1 | Beat is a write |
| bus_word | output | 1 | Beat is 16-bit (else byte) |
| bus_addr | output | AW | Beat address |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Beat completes this cycle |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |
| irq | output | 1 | End-of-count interrupt level |

## Verification
Several rules are checked on every cycle by the assertions:
- the count drops by one per copy, and the memory pointer steps by the signed unit size;
- the enable bit clears on the last copy, and `irq` never coexists with enable;
- a held request only ever comes from an enabled channel;
- the first beat of each copy uses the address that the source-derived direction calls for;
- the bus goes quiet after every write beat.

Some properties can only be shown by the bench scenarios:
- the data that actually lands at the destination;
- the size of each beat;
- that unselected, disabled or repeat-mode requests produce no beats;
- that a request held during a copy yields exactly one extra copy.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int CTL_W   = 8;
  localparam int SEL_W   = 3;
  localparam int NSRC    = 1 << SEL_W;
  localparam int B_WORD  = 3;
  localparam int B_DEC   = 4;
  localparam int B_RPT   = 5;
  localparam int B_IE    = 6;
  localparam int B_EN    = 7;

  localparam logic [SEL_W-1:0] SRC_RXF = 3'd4;
  localparam logic [SEL_W-1:0] SRC_ADC = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} xfer_st_e;

  function automatic logic src_inbound(input logic [SEL_W-1:0] s);
    return (s == SRC_RXF) || (s == SRC_ADC);
  endfunction
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [AW-1:0]    reg_wdata,
  output logic [AW-1:0]    reg_rdata,
  input  logic             xfer_done,
  output logic [AW-1:0]    mar,
  output logic [AW-1:0]    ioar,
  output logic [CW-1:0]    cnt,
  output logic [CTL_W-1:0] ctl,
  output logic             done_flag
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  logic [AW-1:0] step;
  logic [AW-1:0] mar_next;
  logic          wr_mar, wr_ioar, wr_cnt, wr_ctl;

  assign step     = ctl[B_WORD] ? STEP_W : STEP_B;
  assign mar_next = ctl[B_DEC] ? (mar - step) : (mar + step);
  assign wr_mar   = reg_wr && (reg_addr == 2'd0);
  assign wr_ioar  = reg_wr && (reg_addr == 2'd1);
  assign wr_cnt   = reg_wr && (reg_addr == 2'd2);
  assign wr_ctl   = reg_wr && (reg_addr == 2'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      mar       <= '0;
      ioar      <= '0;
      cnt       <= '0;
      ctl       <= '0;
      done_flag <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (xfer_done) begin
        mar <= mar_next;
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          ctl[B_EN] <= 1'b0;
          done_flag <= 1'b1;
        end
      end
      if (wr_mar)  mar  <= reg_wdata;
      if (wr_ioar) ioar <= reg_wdata;
      if (wr_cnt)  cnt  <= reg_wdata[CW-1:0];
      if (wr_ctl) begin
        ctl       <= reg_wdata[CTL_W-1:0];
        done_flag <= 1'b0;
      end
      if (reg_rd) begin
        case (reg_addr)
          2'd0:    reg_rdata <= mar;
          2'd1:    reg_rdata <= ioar;
          2'd2:    reg_rdata <= AW'(cnt);
          default: reg_rdata <= AW'(ctl);
        endcase
      end
    end
  end

  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !wr_cnt) |=> (cnt == $past(cnt) - CW'(1)));

  assert_last_clears_en_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && cnt == CW'(1) && !wr_ctl) |=> !ctl[B_EN]);

  assert_mar_step_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !wr_mar) |=>
      (mar == ($past(ctl[B_DEC]) ? $past(mar) - ($past(ctl[B_WORD]) ? STEP_W : STEP_B)
                                 : $past(mar) + ($past(ctl[B_WORD]) ? STEP_W : STEP_B))));

  assert_ioar_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_ioar |=> $stable(ioar));
endmodule

// File: rtl/dmac_req_sel.sv
module dmac_req_sel
  import dmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  req_vec,
  input  logic [SEL_W-1:0] sel,
  input  logic             go_ok,
  input  logic             start,
  output logic             pend,
  output logic             inbound
);
  logic [NSRC-1:0] sel_hit;
  logic            hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign sel_hit[i] = req_vec[i] && (sel == SEL_W'(i));
  end

  assign hit     = |sel_hit;
  assign inbound = src_inbound(sel);

  always_ff @(posedge clk) begin
    if (rst)        pend <= 1'b0;
    else if (!go_ok) pend <= 1'b0;
    else if (hit)   pend <= 1'b1;
    else if (start) pend <= 1'b0;
  end

  assert_pend_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(go_ok));
endmodule

// File: rtl/dmac_xfer_fsm.sv
module dmac_xfer_fsm
  import dmac_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pend,
  input  logic          go_ok,
  input  logic          inbound,
  input  logic          word,
  input  logic [AW-1:0] mar,
  input  logic [AW-1:0] ioar,
  output logic          start,
  output logic          xfer_done,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_word,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);
  localparam int BW = DW / 2;

  xfer_st_e      st;
  logic [AW-1:0] dst_q;

  assign start     = (st == ST_IDLE) && pend && go_ok;
  assign xfer_done = (st == ST_WR) && bus_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      dst_q     <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_word  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st       <= ST_RD;
          bus_req  <= 1'b1;
          bus_we   <= 1'b0;
          bus_word <= word;
          bus_addr <= inbound ? ioar : mar;
          dst_q    <= inbound ? mar : ioar;
        end
        ST_RD: if (bus_ack) begin
          st        <= ST_WR;
          bus_we    <= 1'b1;
          bus_addr  <= dst_q;
          bus_wdata <= bus_word ? bus_rdata : {{(DW-BW){1'b0}}, bus_rdata[BW-1:0]};
        end
        default: if (bus_ack) begin
          st      <= ST_IDLE;
          bus_req <= 1'b0;
          bus_we  <= 1'b0;
        end
      endcase
    end
  end

  assert_single_pair_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_ack) |=> !bus_req);

  assert_read_first_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> !bus_we);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dmac_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic [2:0]    req_tmr,
  input  logic          req_txe,
  input  logic          req_rxf,
  input  logic          req_adc,
  input  logic          req_ext,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_word,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic [AW-1:0]    mar, ioar;
  logic [CW-1:0]    cnt;
  logic [CTL_W-1:0] ctl;
  logic             done_flag, xfer_done, start, pend, inbound, go_ok;
  logic [NSRC-1:0]  req_vec;

  assign req_vec = {1'b0, req_ext, req_adc, req_rxf, req_txe, req_tmr};
  assign go_ok   = ctl[B_EN] && !ctl[B_RPT] && (cnt != '0);
  assign irq     = done_flag && ctl[B_IE];

  dmac_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .mar(mar), .ioar(ioar), .cnt(cnt), .ctl(ctl), .done_flag(done_flag)
  );

  dmac_req_sel u_sel (
    .clk(clk), .rst(rst), .req_vec(req_vec), .sel(ctl[SEL_W-1:0]),
    .go_ok(go_ok), .start(start), .pend(pend), .inbound(inbound)
  );

  dmac_xfer_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .pend(pend), .go_ok(go_ok), .inbound(inbound),
    .word(ctl[B_WORD]), .mar(mar), .ioar(ioar), .start(start), .xfer_done(xfer_done),
    .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  assert_src_addr_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> (bus_addr == ($past(inbound) ? $past(ioar) : $past(mar))));

  assert_irq_off_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> !ctl[B_EN]);
endmodule

// File: tb/dma_chan_ctrl_bench.sv
module dma_chan_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 16;
  localparam int MEMSZ = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic [2:0]    req_tmr = '0;
  logic          req_txe = 1'b0, req_rxf = 1'b0, req_adc = 1'b0, req_ext = 1'b0;
  logic          bus_req, bus_we, bus_word;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          irq;

  logic [7:0] mem [MEMSZ];
  int  n_tests = 0, n_fail = 0;
  int  rd_beats = 0, wr_beats = 0, size_err = 0, lat = 0;
  logic exp_word = 1'b0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl #(.AW(AW), .CW(CW), .DW(DW)) u_dma_chan_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_tmr(req_tmr), .req_txe(req_txe),
    .req_rxf(req_rxf), .req_adc(req_adc), .req_ext(req_ext), .bus_req(bus_req),
    .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .irq(irq)
  );

  // bus responder: memory model with 0..2 cycles of latency
  always @(negedge clk) begin
    int a;
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      if (lat == 0) begin
        a = int'(bus_addr) % MEMSZ;
        if (bus_word != exp_word) size_err++;
        if (!bus_we) begin
          bus_rdata = bus_word ? {mem[(a+1)%MEMSZ], mem[a]} : {8'h00, mem[a]};
          rd_beats++;
        end else begin
          mem[a] = bus_wdata[7:0];
          if (bus_word) mem[(a+1)%MEMSZ] = bus_wdata[15:8];
          wr_beats++;
        end
        bus_ack = 1'b1;
        lat = int'($urandom % 3);
      end else lat--;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [AW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [AW-1:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic fire(input int s);
    @(negedge clk);
    case (s)
      0, 1, 2: req_tmr[s] = 1'b1;
      3: req_txe = 1'b1;
      4: req_rxf = 1'b1;
      5: req_adc = 1'b1;
      6: req_ext = 1'b1;
      default: begin req_tmr = 3'b111; req_txe = 1'b1; req_rxf = 1'b1; req_adc = 1'b1; req_ext = 1'b1; end
    endcase
    @(negedge clk);
    req_tmr = '0; req_txe = 1'b0; req_rxf = 1'b0; req_adc = 1'b0; req_ext = 1'b0;
  endtask

  task automatic settle();
    repeat (25) @(negedge clk);
  endtask

  function automatic logic is_in(input int s);
    return (s == 4) || (s == 5);
  endfunction

  function automatic logic [AW-1:0] exp_mar(input logic [AW-1:0] s, input int n, input logic w, input logic d);
    int st = w ? 2 : 1;
    return d ? AW'(int'(s) - n*st) : AW'(int'(s) + n*st);
  endfunction

  function automatic logic [7:0] ctl_byte(input logic en, input logic ie, input logic rp,
                                          input logic d, input logic w, input int s);
    return {en, ie, rp, d, w, 3'(s)};
  endfunction

  function automatic logic [15:0] unit_at(input int a, input logic w);
    return w ? {mem[(a+1)%MEMSZ], mem[a%MEMSZ]} : {8'h00, mem[a%MEMSZ]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] d;
    logic [15:0] v;
    int b0;
    void'($urandom(32'h5eed_d0a1));
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      rd_reg(2'(i), d);
      chk(d == '0, "R1 reg after reset", d, 0);
    end
    chk(!irq && !bus_req, "R1 irq/bus_req after reset", {irq, bus_req}, 0);

    // R10: register map readback
    wr_reg(2'd0, 16'h1234); wr_reg(2'd1, 16'h0abc);
    rd_reg(2'd0, d); chk(d == 16'h1234, "R10 mar readback", d, 16'h1234);
    rd_reg(2'd1, d); chk(d == 16'h0abc, "R10 ioar readback", d, 16'h0abc);

    // R2 R3 R5 R6: timer 0, byte, increment, memory -> io, count 3
    exp_word = 1'b0;
    wr_reg(2'd0, 16'd400); wr_reg(2'd1, 16'd20); wr_reg(2'd2, 16'd3);
    wr_reg(2'd3, 16'(ctl_byte(1, 0, 0, 0, 0, 0)));
    b0 = wr_beats;
    for (int k = 0; k < 3; k++) begin
      v = unit_at(400 + k, 1'b0);
      fire(0); settle();
      chk(mem[20] == v[7:0], "R3 outbound byte at io addr", mem[20], v[7:0]);
    end
    chk(wr_beats - b0 == 3 && rd_beats == wr_beats, "R2 one beat pair per request", wr_beats - b0, 3);
    rd_reg(2'd0, d); chk(d == 16'd403, "R5 mar incremented by 1", d, 403);
    rd_reg(2'd1, d); chk(d == 16'd20, "R5 ioar unchanged", d, 20);
    rd_reg(2'd2, d); chk(d == '0, "R6 count exhausted", d, 0);
    rd_reg(2'd3, d); chk(d == 16'h00, "R6 enable cleared", d, 0);
    chk(!irq, "R8 no irq with ie=0", irq, 0);
    b0 = wr_beats; fire(0); settle();
    chk(wr_beats == b0, "R6 request after exhaustion ignored", wr_beats - b0, 0);

    // R3 R5 R8: receive-full, word, decrement, io -> memory, count 2
    exp_word = 1'b1;
    wr_reg(2'd0, 16'd600); wr_reg(2'd1, 16'd30); wr_reg(2'd2, 16'd2);
    wr_reg(2'd3, 16'(ctl_byte(1, 1, 0, 1, 1, 4)));
    v = unit_at(30, 1'b1);
    fire(4); settle();
    chk(irq == 1'b0, "R8 no irq before end", irq, 0);
    fire(4); settle();
    chk(unit_at(600, 1'b1) == v && unit_at(598, 1'b1) == v, "R3 inbound word to memory",
        unit_at(598, 1'b1), v);
    rd_reg(2'd0, d); chk(d == 16'd596, "R5 mar decremented by 2", d, 596);
    chk(irq == 1'b1, "R8 irq at end", irq, 1);
    chk(size_err == 0, "R2 beat size", size_err, 0);
    wr_reg(2'd3, 16'h00);
    chk(irq == 1'b0, "R8 irq cleared by control write", irq, 0);

    // R4: unselected lines and select 7 ignored
    wr_reg(2'd2, 16'd5);
    wr_reg(2'd3, 16'(ctl_byte(1, 0, 0, 0, 0, 5)));
    b0 = wr_beats + rd_beats;
    fire(0); fire(3); fire(4); fire(6); settle();
    chk(wr_beats + rd_beats == b0, "R4 unselected request ignored", wr_beats + rd_beats - b0, 0);
    wr_reg(2'd3, 16'(ctl_byte(1, 0, 0, 0, 0, 7)));
    fire(7); settle();
    chk(wr_beats + rd_beats == b0, "R4 select 7 has no source", wr_beats + rd_beats - b0, 0);
    rd_reg(2'd2, d); chk(d == 16'd5, "R4 count untouched", d, 5);

    // R7: disabled and repeat-set channels ignore requests
    wr_reg(2'd3, 16'(ctl_byte(0, 0, 0, 0, 0, 6)));
    fire(6); settle();
    chk(wr_beats + rd_beats == b0, "R7 disabled ignores request", wr_beats + rd_beats - b0, 0);
    wr_reg(2'd3, 16'(ctl_byte(1, 0, 1, 0, 0, 6)));
    fire(6); settle();
    chk(wr_beats + rd_beats == b0, "R7 repeat bit blocks request", wr_beats + rd_beats - b0, 0);

    // R9: second request during a transfer is held and served
    exp_word = 1'b0;
    wr_reg(2'd0, 16'd700); wr_reg(2'd2, 16'd4);
    wr_reg(2'd3, 16'(ctl_byte(1, 0, 0, 0, 0, 6)));
    b0 = wr_beats;
    fire(6); fire(6); settle();
    chk(wr_beats - b0 == 2, "R9 held request served", wr_beats - b0, 2);
    rd_reg(2'd2, d); chk(d == 16'd2, "R9 count after two", d, 2);

    // random configurations
    for (int it = 0; it < 40; it++) begin
      int s, n, io, m0;
      logic w, dn, ie;
      s = int'($urandom % 7); n = 1 + int'($urandom % 4);
      w = 1'($urandom); dn = 1'($urandom); ie = 1'($urandom);
      io = 16 + 2 * int'($urandom % 16); m0 = 300 + 2 * int'($urandom % 200);
      exp_word = w;
      wr_reg(2'd0, AW'(m0)); wr_reg(2'd1, AW'(io)); wr_reg(2'd2, CW'(n));
      wr_reg(2'd3, 16'(ctl_byte(1, ie, 0, dn, w, s)));
      v = is_in(s) ? unit_at(io, w) : unit_at(int'(exp_mar(AW'(m0), n - 1, w, dn)), w);
      b0 = wr_beats;
      for (int k = 0; k < n; k++) begin fire(s); settle(); end
      chk(wr_beats - b0 == n, "R2 random beat count", wr_beats - b0, n);
      if (is_in(s))
        chk(unit_at(int'(exp_mar(AW'(m0), n - 1, w, dn)), w) == v, "R3 random inbound data",
            unit_at(int'(exp_mar(AW'(m0), n - 1, w, dn)), w), v);
      else
        chk(unit_at(io, w) == v, "R3 random outbound data", unit_at(io, w), v);
      rd_reg(2'd0, d);
      chk(d == exp_mar(AW'(m0), n, w, dn), "R5 random mar", d, exp_mar(AW'(m0), n, w, dn));
      chk(irq == ie, "R8 random irq", irq, ie);
      wr_reg(2'd3, 16'h00);
    end
    chk(size_err == 0, "R2 random beat size", size_err, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule